// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block lets several requesters share one word-addressed memory through a single arbitrated path. A request names an operation, a word address, up to two operands and arrives on a requester port. The unit performs the whole read-modify-write indivisibly: it reads the word, computes the new value, writes it back, and returns the value it read. The response carries the index of the requester port. Plain loads and stores use the same path, so lock words, counters and ordinary data all live in one array.

Each requester port has a valid/ready handshake. A round-robin arbiter grants at most one request per cycle. The granted operation reads memory in the next cycle and writes in the cycle after that. While an operation sits between its read and its write, its address is locked: a request for the same word is held back for one cycle, so no other access can fall between the read and the write. Responses appear two cycles after the handshake, in grant order, on one shared response channel.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset no response is valid, no ready is asserted while inputs are idle, and every memory word reads as 0.
- R2: Op code 0 (load) returns the word and leaves it unchanged. Op code 1 (store) writes operand A and returns the previous word. Both report ok = 1.
- R3: Op code 2 (swap) returns the old word, writes operand A, and reports ok = 1.
- R4: Op code 3 (test-and-set) returns the old word and writes 1 only when that word was 0. ok is 1 exactly when the old word was 0.
- R5: Op code 4 (fetch-add) stores old + operand A, and op code 5 (fetch-increment) stores old + 1. Both return the old word, report ok = 1 and wrap modulo 2^DW.
- R6: Op code 6 (compare-and-swap) writes operand B only when the old word equals operand A. It returns the old word with ok = 1 on a match and ok = 0 otherwise. On a mismatch memory is unchanged.
- R7: At most one ready is high per cycle, and only for a port whose valid is high. Priority rotates round-robin, starting after the last granted port. After reset port 0 has the highest priority.
- R8: A request whose address equals the address of the operation accepted in the previous cycle is not accepted in the current cycle. Two accepted operations in consecutive cycles never share an address.
- R9: Every accepted request produces exactly one response exactly two cycles after its handshake. The response carries the requester's port index as its ID, and responses come out in grant order.
- R10: A store of 0 to a lock word releases it, so a following test-and-set on that word succeeds.
- R11: Op code 7 behaves as a load: it returns the word with ok = 1 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_REQ | Request valid per port |
| req_ready_o | output | N_REQ | Request accepted this cycle, per port |
| req_op_i | input | N_REQ*3 | Op code per port, port i at bits [3i+2:3i] |
| req_addr_i | input | N_REQ*AW | Word address per port |
| req_opa_i | input | N_REQ*DW | Operand A (store/swap value, addend, expected value) |
| req_opb_i | input | N_REQ*DW | Operand B (compare-and-swap new value) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_id_o | output | $clog2(N_REQ) | Port index of the responding requester |
| rsp_data_o | output | DW | Word read before the operation |
| rsp_ok_o | output | 1 | Success flag (test-and-set and compare-and-swap) |

## Verification
The assertions check the handshake and ordering rules on every cycle: a single grant that only goes to a valid port, no two consecutive accepted operations on one address, and a response with the correct ID exactly two cycles after each handshake and at no other time. The data semantics of each operation, the wrap of the increment, the round-robin order, and the order in which the lock reshuffles simultaneous requests can only be seen in the bench scenarios. There a reference memory model predicts every returned word and ok flag in acceptance order.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FADD  = 3'd4,
    OP_FINC  = 3'd5,
    OP_CAS   = 3'd6
  } op_e;
endpackage

// File: rtl/atomic_rr_arb.sv
module atomic_rr_arb #(
  parameter int N_REQ = 4,
  localparam int IW = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IW-1:0]    gnt_idx_o,
  output logic             gnt_any_o
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    gnt_any_o = 1'b0;
    for (int k = 1; k <= N_REQ; k++) begin
      int j;
      j = (int'(last_q) + k) % N_REQ;
      if (!gnt_any_o && req_i[j]) begin
        gnt_any_o = 1'b1;
        gnt_o[j]  = 1'b1;
        gnt_idx_o = IW'(j);
      end
    end
  end

  // reset points at the last port so port 0 wins first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_q <= IW'(N_REQ - 1);
    else if (gnt_any_o) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atomic_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   old_i,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  output logic            wr_en_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            ok_o
);
  logic old_zero, old_match;

  assign old_zero  = (old_i == '0);
  assign old_match = (old_i == opa_i);

  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = old_i;
    ok_o      = 1'b1;
    case (op_i)
      OP_STORE, OP_SWAP: begin
        wr_en_o   = 1'b1;
        wr_data_o = opa_i;
      end
      OP_TAS: begin
        wr_en_o   = old_zero;
        wr_data_o = DW'(1);
        ok_o      = old_zero;
      end
      OP_FADD: begin
        wr_en_o   = 1'b1;
        wr_data_o = old_i + opa_i;
      end
      OP_FINC: begin
        wr_en_o   = 1'b1;
        wr_data_o = old_i + DW'(1);
      end
      OP_CAS: begin
        wr_en_o   = old_match;
        wr_data_o = opb_i;
        ok_o      = old_match;
      end
      default: ;  // load and unused code: read only
    endcase
  end
endmodule

// File: rtl/atomic_word_mem.sv
module atomic_word_mem #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int AW    = 6,
  parameter int DW    = 32,
  localparam int IW   = $clog2(N_REQ)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_REQ-1:0]      req_valid_i,
  output logic [N_REQ-1:0]      req_ready_o,
  input  logic [N_REQ*OP_W-1:0] req_op_i,
  input  logic [N_REQ*AW-1:0]   req_addr_i,
  input  logic [N_REQ*DW-1:0]   req_opa_i,
  input  logic [N_REQ*DW-1:0]   req_opb_i,
  output logic                  rsp_valid_o,
  output logic [IW-1:0]         rsp_id_o,
  output logic [DW-1:0]         rsp_data_o,
  output logic                  rsp_ok_o
);
  logic [OP_W-1:0] op_arr   [N_REQ];
  logic [AW-1:0]   addr_arr [N_REQ];
  logic [DW-1:0]   opa_arr  [N_REQ];
  logic [DW-1:0]   opb_arr  [N_REQ];
  logic [N_REQ-1:0] cand;

  // read stage
  logic            s1_valid;
  logic [OP_W-1:0] s1_op;
  logic [AW-1:0]   s1_addr;
  logic [DW-1:0]   s1_a, s1_b;
  logic [IW-1:0]   s1_id;
  // write stage
  logic            s2_valid;
  logic [OP_W-1:0] s2_op;
  logic [AW-1:0]   s2_addr;
  logic [DW-1:0]   s2_a, s2_b, s2_old;
  logic [IW-1:0]   s2_id;

  logic [IW-1:0] gnt_idx;
  logic          gnt_any;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, ok;

  for (genvar g = 0; g < N_REQ; g++) begin : g_unpack
    assign op_arr[g]   = req_op_i[g*OP_W +: OP_W];
    assign addr_arr[g] = req_addr_i[g*AW +: AW];
    assign opa_arr[g]  = req_opa_i[g*DW +: DW];
    assign opb_arr[g]  = req_opb_i[g*DW +: DW];
    // word between read and write is locked
    assign cand[g] = req_valid_i[g] && !(s1_valid && addr_arr[g] == s1_addr);
  end

  atomic_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (cand),
    .gnt_o     (req_ready_o),
    .gnt_idx_o (gnt_idx),
    .gnt_any_o (gnt_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_addr  <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_id    <= '0;
    end else begin
      s1_valid <= gnt_any;
      if (gnt_any) begin
        s1_op   <= op_arr[gnt_idx];
        s1_addr <= addr_arr[gnt_idx];
        s1_a    <= opa_arr[gnt_idx];
        s1_b    <= opb_arr[gnt_idx];
        s1_id   <= gnt_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_op    <= '0;
      s2_addr  <= '0;
      s2_a     <= '0;
      s2_b     <= '0;
      s2_old   <= '0;
      s2_id    <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_op   <= s1_op;
        s2_addr <= s1_addr;
        s2_a    <= s1_a;
        s2_b    <= s1_b;
        s2_old  <= rd_data;
        s2_id   <= s1_id;
      end
    end
  end

  atomic_word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (s1_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (s2_valid && wr_en),
    .wr_addr_i (s2_addr),
    .wr_data_i (wr_data)
  );

  atomic_rmw_alu #(.DW(DW)) u_alu (
    .op_i      (s2_op),
    .old_i     (s2_old),
    .opa_i     (s2_a),
    .opb_i     (s2_b),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .ok_o      (ok)
  );

  assign rsp_valid_o = s2_valid;
  assign rsp_id_o    = s2_id;
  assign rsp_data_o  = s2_old;
  assign rsp_ok_o    = ok;
endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker #(
  parameter int N_REQ = 4,
  parameter int AW    = 6,
  localparam int IW   = $clog2(N_REQ)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_REQ-1:0]    req_valid_i,
  input logic [N_REQ-1:0]    req_ready_o,
  input logic [N_REQ*AW-1:0] req_addr_i,
  input logic                rsp_valid_o,
  input logic [IW-1:0]       rsp_id_o
);
  logic          hs;
  logic [IW-1:0] hs_idx;
  logic [AW-1:0] hs_addr;

  always_comb begin
    hs      = 1'b0;
    hs_idx  = '0;
    hs_addr = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_valid_i[i] && req_ready_o[i]) begin
        hs      = 1'b1;
        hs_idx  = IW'(i);
        hs_addr = req_addr_i[i*AW +: AW];
      end
    end
  end

  p_single_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  p_grant_needs_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);

  p_addr_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && $past(hs)) |-> (hs_addr != $past(hs_addr)));

  p_rsp_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |-> ##2 rsp_valid_o);

  p_rsp_id_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_id_o == $past(hs_idx, 2)));

  p_no_spurious_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(hs, 2));
endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.N_REQ(N_REQ), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_id_o    (rsp_id_o)
);

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/1ps
module atomic_rmw_unit_test;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int IW = 2;

  typedef struct {
    int          id;
    logic [31:0] data;
    logic        ok;
    string       tag;
    int          cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        v_b    [N];
  logic [2:0]  op_b   [N];
  logic [5:0]  addr_b [N];
  logic [31:0] a_b    [N];
  logic [31:0] b_b    [N];

  logic [N-1:0]    req_valid, req_ready;
  logic [N*3-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_opa, req_opb;
  logic            rsp_valid, rsp_ok;
  logic [IW-1:0]   rsp_id;
  logic [DW-1:0]   rsp_data;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]          = v_b[i];
      req_op[i*3 +: 3]      = op_b[i];
      req_addr[i*AW +: AW]  = addr_b[i];
      req_opa[i*DW +: DW]   = a_b[i];
      req_opb[i*DW +: DW]   = b_b[i];
    end
  end

  atomic_rmw_unit #(.N_REQ(N), .AW(AW), .DW(DW)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_opa_i   (req_opa),
    .req_opb_i   (req_opb),
    .rsp_valid_o (rsp_valid),
    .rsp_id_o    (rsp_id),
    .rsp_data_o  (rsp_data),
    .rsp_ok_o    (rsp_ok)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mdl [64];
  exp_t exp_q [$];
  int   acc_q [$];
  int   cyc = 0;
  int   viol = 0;
  bit   prev_hs = 1'b0;
  logic [5:0] prev_addr = '0;

  task automatic chk(bit good, string tag, string what, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R3";
      3'd3:       return "R4";
      3'd4, 3'd5: return "R5";
      3'd6:       return "R6";
      default:    return "R11";
    endcase
  endfunction

  // monitor: check responses, then model accepted requests
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected response", 32'(rsp_id), 32'hffffffff);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_data == e.data, e.tag, "old value", rsp_data, e.data);
          chk(rsp_ok == e.ok, e.tag, "ok flag", 32'(rsp_ok), 32'(e.ok));
          chk(int'(rsp_id) == e.id, "R9", "response id", 32'(rsp_id), 32'(e.id));
          chk(cyc == e.cyc + 2, "R9", "response cycle", 32'(cyc), 32'(e.cyc + 2));
        end
      end
      begin
        bit hs_now;
        hs_now = 1'b0;
        for (int i = 0; i < N; i++) begin
          if (v_b[i] && req_ready[i]) begin
            exp_t e;
            logic [31:0] old;
            hs_now = 1'b1;
            old = mdl[addr_b[i]];
            e.id = i; e.data = old; e.ok = 1'b1; e.tag = op_tag(op_b[i]); e.cyc = cyc;
            case (op_b[i])
              3'd1, 3'd2: mdl[addr_b[i]] = a_b[i];
              3'd3: begin e.ok = (old == 0); if (old == 0) mdl[addr_b[i]] = 32'd1; end
              3'd4: mdl[addr_b[i]] = old + a_b[i];
              3'd5: mdl[addr_b[i]] = old + 32'd1;
              3'd6: begin e.ok = (old == a_b[i]); if (old == a_b[i]) mdl[addr_b[i]] = b_b[i]; end
              default: ;
            endcase
            exp_q.push_back(e);
            acc_q.push_back(i);
            if (prev_hs && prev_addr == addr_b[i]) viol++;
            prev_addr = addr_b[i];
          end
        end
        prev_hs = hs_now;
      end
    end
  end

  task automatic drive(int p, logic [2:0] op, logic [5:0] a, logic [31:0] x, logic [31:0] y);
    op_b[p] = op; addr_b[p] = a; a_b[p] = x; b_b[p] = y; v_b[p] = 1'b1;
    do @(negedge clk); while (!req_ready[p]);
    @(posedge clk);
    #2;
    v_b[p] = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #2;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    for (int i = 0; i < N; i++) begin
      v_b[i] = 1'b0; op_b[i] = '0; addr_b[i] = '0; a_b[i] = '0; b_b[i] = '0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(req_ready == '0, "R1", "ready while idle", 32'(req_ready), 32'h0);
    @(posedge clk); #2;

    // R7: all ports at once, port 0 first after reset; R1 memory reads 0
    acc_q.delete();
    fork
      drive(0, 3'd0, 6'd0, 0, 0);
      drive(1, 3'd0, 6'd1, 0, 0);
      drive(2, 3'd0, 6'd2, 0, 0);
      drive(3, 3'd0, 6'd3, 0, 0);
    join
    settle();
    for (int k = 0; k < 4; k++)
      chk(acc_q.size() > k && acc_q[k] == k, "R7", "round-robin order", 32'(acc_q.size() > k ? acc_q[k] : -1), 32'(k));

    // R8: two increments on one word; lock defers the second behind port 2
    acc_q.delete();
    fork
      drive(0, 3'd5, 6'd5, 0, 0);
      drive(1, 3'd5, 6'd5, 0, 0);
      drive(2, 3'd5, 6'd6, 0, 0);
    join
    settle();
    chk(acc_q.size() == 3 && acc_q[0] == 0 && acc_q[1] == 2 && acc_q[2] == 1, "R8",
        "lock reorder 0,2,1", 32'(acc_q.size() == 3 ? acc_q[1] : -1), 32'd2);
    drive(3, 3'd0, 6'd5, 0, 0);  // expects 2

    // serial operation semantics
    drive(1, 3'd1, 6'd7, 32'h10, 0);        // R2 store
    drive(1, 3'd4, 6'd7, 32'h5, 0);         // R5 fetch-add
    drive(1, 3'd5, 6'd7, 0, 0);             // R5 fetch-inc
    drive(1, 3'd0, 6'd7, 0, 0);             // R2 load 0x16
    drive(2, 3'd2, 6'd7, 32'haa, 0);        // R3 swap
    drive(2, 3'd0, 6'd7, 0, 0);             // R3 reads 0xaa
    drive(0, 3'd3, 6'd8, 0, 0);             // R4 tas free
    drive(0, 3'd3, 6'd8, 0, 0);             // R4 tas held
    drive(3, 3'd0, 6'd8, 0, 0);             // R4 still 1
    drive(3, 3'd1, 6'd8, 0, 0);             // R10 release
    drive(0, 3'd3, 6'd8, 0, 0);             // R10 tas succeeds
    drive(2, 3'd6, 6'd9, 0, 32'h55);        // R6 match
    drive(2, 3'd6, 6'd9, 0, 32'h66);        // R6 mismatch
    drive(2, 3'd0, 6'd9, 0, 0);             // R6 unchanged 0x55
    drive(1, 3'd1, 6'd10, 32'hffffffff, 0); // R5 wrap setup
    drive(1, 3'd5, 6'd10, 0, 0);
    drive(1, 3'd0, 6'd10, 0, 0);            // R5 wrapped to 0
    drive(1, 3'd4, 6'd10, 32'hfffffffe, 0);
    drive(1, 3'd4, 6'd10, 32'h3, 0);        // R5 add wrap
    drive(3, 3'd7, 6'd9, 32'h1, 32'h2);     // R11 code 7 reads
    drive(3, 3'd0, 6'd9, 0, 0);             // R11 no write
    settle();

    // mixed concurrent traffic on two ports
    fork
      begin
        drive(1, 3'd4, 6'd20, 32'd3, 0);
        drive(1, 3'd4, 6'd20, 32'd4, 0);
        drive(1, 3'd2, 6'd21, 32'h77, 0);
      end
      begin
        drive(3, 3'd4, 6'd20, 32'd10, 0);
        drive(3, 3'd6, 6'd21, 32'h77, 32'h99);
        drive(3, 3'd0, 6'd20, 0, 0);
      end
    join
    settle();

    chk(exp_q.size() == 0, "R9", "outstanding responses", 32'(exp_q.size()), 32'h0);
    chk(viol == 0, "R8", "same address in consecutive grants", 32'(viol), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule